// File: doc/BRIEF.md
# Execute-Stage ALU with Sign/Zero Condition Tracking

This block is the execute stage of a small sequential 64-bit processor core. From the decoded opcode class (`icode`) and its function code (`ifun`), it works out the result word `val_e` in the same cycle. Arithmetic and logic operations select add, subtract, AND or XOR. A register-to-register move or conditional move passes the source operand through unchanged. A register-to-memory store uses the same adder to form its effective address from the base register and the displacement.

The block keeps condition state in a small state machine. Only arithmetic/logic operations write it. It has three states: `FLG_ZERO` for a zero result, `FLG_NEG` for a result with its top bit set, and `FLG_POS` for any other result. The machine resets into `FLG_ZERO`. At each rising edge where `icode` is the arithmetic/logic class, it takes the transition `T_ZERO`, `T_NEG` or `T_POS` for the result of that cycle. In every other cycle it takes `T_HOLD` and keeps its state. The sign and zero flags are decoded from the state. The conditional-move predicate `cond_met` is worked out from the stored flags and the current `ifun`. There is no overflow or carry flag.

Top module: `cc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the flags become SF=0 and ZF=1 (state `FLG_ZERO`).
- R2: With `icode`=6 (arithmetic/logic) and `ifun`=0, `val_e` equals `val_b + val_a` modulo 2^W, in the same cycle.
- R3: With `icode`=6 and `ifun`=1, `val_e` equals `val_b - val_a` modulo 2^W.
- R4: With `icode`=6, `ifun`=2 gives `val_b & val_a` and `ifun`=3 gives `val_b ^ val_a`. Any other `ifun` gives 0.
- R5: After a rising edge with `icode`=6, ZF is 1 exactly when that cycle's `val_e` was zero.
- R6: After a rising edge with `icode`=6, SF equals bit W-1 of that cycle's `val_e`. SF and ZF are never both 1.
- R7: After a rising edge with `icode` other than 6 (and `rst` low), SF and ZF keep their previous values.
- R8: `cond_met` is decoded from `ifun` and the stored flags as follows: 0 gives 1; 1 (le) gives SF|ZF; 2 (l) gives SF; 3 (e) gives ZF; 4 (ne) gives !ZF; 5 (ge) gives !SF; 6 (g) gives !SF&!ZF; 7 to 15 give 0.
- R9: With `icode`=2 (move and conditional move), `val_e` equals `val_a` for every `ifun`.
- R10: With `icode`=4 (register-to-memory store), `val_e` equals `val_b + val_c` modulo 2^W.
- R11: For any `icode` other than 2, 4 and 6, `val_e` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| icode | input | 4 | Opcode class of the current instruction |
| ifun | input | 4 | Function code: ALU operation or move condition |
| val_a | input | W | First register operand |
| val_b | input | W | Second register operand |
| val_c | input | W | Immediate displacement |
| val_e | output | W | Execute result or effective address |
| flag_sf | output | 1 | Stored sign flag |
| flag_zf | output | 1 | Stored zero flag |
| cond_met | output | 1 | Move condition evaluated against stored flags |

## Verification
The assertions watch the flag state machine on every cycle. They check that it holds when no arithmetic/logic operation is present, that its zero and sign update follow the previous cycle's result, that it returns to `FLG_ZERO` after reset, and that SF and ZF are never both set. On every cycle they also check the move pass-through and the le predicate. The arithmetic itself, with its wrap-around, borrow and the value of every operation for each operand pair, can only be shown by the bench's exhaustive operand sweeps at a 6-bit width. The same holds for the full condition table in each of the three flag states and the zero result of unused opcodes.

// File: rtl/cc_alu_pkg.sv
package cc_alu_pkg;

    localparam logic [3:0] IC_MOVE  = 4'd2;
    localparam logic [3:0] IC_STORE = 4'd4;
    localparam logic [3:0] IC_ALU   = 4'd6;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3
    } alu_op_e;

    typedef enum logic [3:0] {
        CND_ALWAYS = 4'd0,
        CND_LE     = 4'd1,
        CND_LT     = 4'd2,
        CND_EQ     = 4'd3,
        CND_NE     = 4'd4,
        CND_GE     = 4'd5,
        CND_GT     = 4'd6
    } cond_e;

    typedef enum logic [1:0] {
        FLG_ZERO = 2'd0,
        FLG_NEG  = 2'd1,
        FLG_POS  = 2'd2
    } flag_state_e;

endpackage

// File: rtl/cc_alu_adder.sv
module cc_alu_adder #(
    parameter int W = 64
) (
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic         do_sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] y_eff;

    always_comb begin
        y_eff = do_sub ? ~op_y : op_y;
        sum   = op_x + y_eff + {{(W-1){1'b0}}, do_sub};
    end
endmodule

// File: rtl/cc_alu_result.sv
module cc_alu_result
    import cc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [3:0]   icode,
    input  logic [3:0]   ifun,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    output logic [W-1:0] val_e
);
    logic         is_alu;
    logic         is_store;
    logic         sub_sel;
    logic [W-1:0] add_y;
    logic [W-1:0] add_sum;

    always_comb begin
        is_alu   = (icode == IC_ALU);
        is_store = (icode == IC_STORE);
        sub_sel  = is_alu && (ifun == OP_SUB);
        add_y    = is_store ? val_c : val_a;
    end

    cc_alu_adder #(.W(W)) u_adder (
        .op_x   (val_b),
        .op_y   (add_y),
        .do_sub (sub_sel),
        .sum    (add_sum)
    );

    always_comb begin
        val_e = '0;
        if (is_alu) begin
            unique case (ifun)
                OP_ADD, OP_SUB: val_e = add_sum;
                OP_AND:         val_e = val_b & val_a;
                OP_XOR:         val_e = val_b ^ val_a;
                default:        val_e = '0;
            endcase
        end else if (is_store) begin
            val_e = add_sum;
        end else if (icode == IC_MOVE) begin
            val_e = val_a;
        end
    end
endmodule

// File: rtl/cc_alu_flags.sv
module cc_alu_flags
    import cc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd_en,
    input  logic [W-1:0] result,
    output logic         sf,
    output logic         zf
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLG_ZERO;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (upd_en) begin
            if (result == '0)         state_d = FLG_ZERO;
            else if (result[W-1])     state_d = FLG_NEG;
            else                      state_d = FLG_POS;
        end
    end

    always_comb begin
        sf = 1'b0;
        zf = 1'b0;
        unique case (state_q)
            FLG_ZERO: zf = 1'b1;
            FLG_NEG:  sf = 1'b1;
            FLG_POS:  ;
            default:  zf = 1'b1;
        endcase
    end
endmodule

// File: rtl/cc_alu_cond.sv
module cc_alu_cond
    import cc_alu_pkg::*;
(
    input  logic [3:0] ifun,
    input  logic       sf,
    input  logic       zf,
    output logic       met
);
    always_comb begin
        unique case (ifun)
            CND_ALWAYS: met = 1'b1;
            CND_LE:     met = sf | zf;
            CND_LT:     met = sf;
            CND_EQ:     met = zf;
            CND_NE:     met = ~zf;
            CND_GE:     met = ~sf;
            CND_GT:     met = ~sf & ~zf;
            default:    met = 1'b0;
        endcase
    end
endmodule

// File: rtl/cc_alu.sv
module cc_alu
    import cc_alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [3:0]   icode,
    input  logic [3:0]   ifun,
    input  logic [W-1:0] val_a,
    input  logic [W-1:0] val_b,
    input  logic [W-1:0] val_c,
    output logic [W-1:0] val_e,
    output logic         flag_sf,
    output logic         flag_zf,
    output logic         cond_met
);
    logic alu_upd;

    assign alu_upd = (icode == IC_ALU);

    cc_alu_result #(.W(W)) u_result (
        .icode (icode),
        .ifun  (ifun),
        .val_a (val_a),
        .val_b (val_b),
        .val_c (val_c),
        .val_e (val_e)
    );

    cc_alu_flags #(.W(W)) u_flags (
        .clk    (clk),
        .rst    (rst),
        .upd_en (alu_upd),
        .result (val_e),
        .sf     (flag_sf),
        .zf     (flag_zf)
    );

    cc_alu_cond u_cond (
        .ifun (ifun),
        .sf   (flag_sf),
        .zf   (flag_zf),
        .met  (cond_met)
    );
endmodule

// File: rtl/cc_alu_checker.sv
module cc_alu_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic [3:0]   icode,
    input logic [3:0]   ifun,
    input logic [W-1:0] val_a,
    input logic [W-1:0] val_e,
    input logic         flag_sf,
    input logic         flag_zf,
    input logic         cond_met
);
    AST_RESET_ZERO: assert property (@(posedge clk) rst |=> (flag_zf && !flag_sf)); // R1
    AST_ZF_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (icode == 4'd6) |=> (flag_zf == ($past(val_e) == '0))); // R5
    AST_SF_UPDATE: assert property (@(posedge clk) disable iff (rst)
        (icode == 4'd6) |=> (flag_sf == $past(val_e[W-1]))); // R6
    AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flag_sf && flag_zf)); // R6
    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (icode != 4'd6) |=> $stable({flag_sf, flag_zf})); // R7
    AST_LE_COND: assert property (@(posedge clk) disable iff (rst)
        (ifun == 4'd1) |-> (cond_met == (flag_sf || flag_zf))); // R8
    AST_MOVE_PASS: assert property (@(posedge clk) disable iff (rst)
        (icode == 4'd2) |-> (val_e == val_a)); // R9
endmodule

bind cc_alu cc_alu_checker #(.W(W)) u_cc_alu_checker (
    .clk      (clk),
    .rst      (rst),
    .icode    (icode),
    .ifun     (ifun),
    .val_a    (val_a),
    .val_e    (val_e),
    .flag_sf  (flag_sf),
    .flag_zf  (flag_zf),
    .cond_met (cond_met)
);

// File: tb/cc_alu_bench.sv
`timescale 1ns/100ps
module cc_alu_bench;
    localparam int W = 6;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst;
    logic [3:0]   icode, ifun;
    logic [W-1:0] val_a, val_b, val_c;
    logic [W-1:0] val_e;
    logic         flag_sf, flag_zf, cond_met;

    int total = 0;
    int bad   = 0;
    logic m_sf, m_zf;

    always #2.5 clk = ~clk;

    cc_alu #(.W(W)) u_cc_alu (
        .clk(clk), .rst(rst), .icode(icode), .ifun(ifun),
        .val_a(val_a), .val_b(val_b), .val_c(val_c),
        .val_e(val_e), .flag_sf(flag_sf), .flag_zf(flag_zf),
        .cond_met(cond_met)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_result(input logic [3:0] ic, input logic [3:0] fn,
                                                input logic [W-1:0] a, input logic [W-1:0] b,
                                                input logic [W-1:0] c);
        if (ic == 4'd6) begin
            case (fn)
                4'd0: return W'(b + a);
                4'd1: return W'(b - a);
                4'd2: return b & a;
                4'd3: return b ^ a;
                default: return '0;
            endcase
        end
        if (ic == 4'd4) return W'(b + c);
        if (ic == 4'd2) return a;
        return '0;
    endfunction

    function automatic logic exp_cond(input logic [3:0] fn, input logic s, input logic z);
        case (fn)
            4'd0: return 1'b1;
            4'd1: return s | z;
            4'd2: return s;
            4'd3: return z;
            4'd4: return !z;
            4'd5: return !s;
            4'd6: return !s && !z;
            default: return 1'b0;
        endcase
    endfunction

    // One cycle: drive, check combinational result, clock, check flags
    task automatic step(input string req, input logic [3:0] ic, input logic [3:0] fn,
                        input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c);
        logic [W-1:0] e;
        @(negedge clk);
        icode = ic; ifun = fn; val_a = a; val_b = b; val_c = c;
        #1;
        e = exp_result(ic, fn, a, b, c);
        check(req, 64'(val_e), 64'(e));
        check("R8", 64'(cond_met), 64'(exp_cond(fn, m_sf, m_zf)));
        if (ic == 4'd6) begin
            m_zf = (e == '0);
            m_sf = e[W-1];
        end
        @(posedge clk);
        #1;
        check(ic == 4'd6 ? "R5" : "R7", 64'(flag_zf), 64'(m_zf));
        check(ic == 4'd6 ? "R6" : "R7", 64'(flag_sf), 64'(m_sf));
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; icode = 4'd6; ifun = 4'd0;
        val_a = '0; val_b = 1; val_c = '0;
        m_sf = 1'b0; m_zf = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check("R1", 64'(flag_zf), 64'd1);
        check("R1", 64'(flag_sf), 64'd0);
        rst = 1'b0;

        // R2 R3 R4 R5 R6: exhaustive operands for each ALU function
        for (int f = 0; f < 4; f++)
            for (int a = 0; a < N; a++)
                for (int b = 0; b < N; b++)
                    step(f == 0 ? "R2" : (f == 1 ? "R3" : "R4"), 4'd6, 4'(f), W'(a), W'(b), '0);
        // R4: unused ALU function codes give zero
        for (int f = 4; f < 16; f++)
            step("R4", 4'd6, 4'(f), W'(5), W'(9), '0);

        // R8 R9: every condition code in each flag state; moves never touch flags
        for (int s = 0; s < 3; s++) begin
            step("R6", 4'd6, 4'd1, W'(s == 1 ? 1 : 0), W'(s == 2 ? 1 : 0), '0);
            for (int f = 0; f < 16; f++)
                step("R9", 4'd2, 4'(f), W'(f * 3 + s), W'(7), W'(11));
        end

        // R10: store address sweep, flags held (R7)
        step("R3", 4'd6, 4'd1, W'(1), W'(0), '0);
        for (int b = 0; b < N; b++)
            for (int c = 0; c < N; c++)
                step("R10", 4'd4, 4'd0, W'(b ^ c), W'(b), W'(c));

        // R11: other opcode classes give zero, flags held (R7)
        for (int ic = 0; ic < 16; ic++)
            if (ic != 2 && ic != 4 && ic != 6)
                step("R11", 4'(ic), 4'd0, W'(13), W'(21), W'(34));

        // R1: reset from a negative flag state
        step("R6", 4'd6, 4'd1, W'(2), W'(1), '0);
        @(negedge clk);
        rst = 1'b1; icode = 4'd0;
        @(posedge clk);
        #1;
        check("R1", 64'(flag_zf), 64'd1);
        check("R1", 64'(flag_sf), 64'd0);
        m_sf = 1'b0; m_zf = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        step("R7", 4'd2, 4'd3, W'(4), W'(0), '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule